// File: doc/BRIEF.md
# Six-Channel Serial-Programmed Resistor Setting Controller

This block is the digital core of a six-channel, 256-step programmable resistor. A host writes settings over a three-wire serial port: a serial clock, a data line and an active-low select. Each frame carries a channel address and an 8-bit code. When the select returns high after a well-formed frame, the code is loaded into the latch of the addressed channel. The six stored codes drive the resistor ladders, which are outside this block.

All latches hold midscale after reset. A preset input returns them to midscale at any time. A shutdown input switches every channel into its power-saving state: the A terminal is open and the wiper is shorted to B. The stored codes are kept through shutdown, so the channels return to their previous settings when it is released. The serial lines are asynchronous to the system clock. They are resynchronised and edge-detected inside the block.

Top module: `dpot_serial_ctrl`

## Requirements
- R1: A frame holds 11 bits, sampled on rising serial-clock edges while select is low. The 3 address bits come first, then the 8 code bits, and each field is sent most significant bit first.
- R2: A latch is loaded only when select rises after exactly 11 serial-clock edges. A frame with fewer or more edges changes no latch.
- R3: A frame with address 0 to 5 writes its code to that channel only. All other channels keep their values, and channels may be written in any order.
- R4: A frame with address 6 or 7 changes no latch.
- R5: After reset every channel code reads 0x80, and both switch-state outputs read 0.
- R6: While preset is high, every channel code becomes 0x80 at the next system-clock edge. Preset wins over a serial write that completes on the same edge.
- R7: While shutdown is high, every channel drives A-open = 1 and wiper-to-B = 1. No stored code changes, and when shutdown drops both outputs return to 0 with the earlier codes still in place.
- R8: A high level on select clears the edge count, so an aborted partial frame does not disturb the frame that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock; data sampled on its rising edge |
| sdi | input | 1 | Serial data in |
| cs_n | input | 1 | Active-low frame select; its rising edge ends a frame |
| preset | input | 1 | Forces every channel to midscale while high |
| shutdown | input | 1 | Puts every channel in its power-saving switch state |
| ch_code | output | 48 | Six 8-bit channel codes; channel k at bits [8k+7:8k] |
| ch_a_open | output | 6 | Per channel: A terminal disconnected |
| ch_wb_short | output | 6 | Per channel: wiper tied to the B terminal |

## Verification
The bench uses the default parameters: six channels, a 3-bit address, 8-bit codes and two synchroniser stages. The 3-bit address leaves codes 6 and 7 unmapped, so writes to them can be issued and shown to have no effect. The fixed two-stage synchroniser gives a known delay from the rising edge of select to the latch load. This lets the bench assert preset on exactly the edge where a write lands and observe that preset wins.

// File: rtl/dpot_pkg.sv
package dpot_pkg;

  // Midscale code for a code width w: only the top bit is set.
  function automatic int mid_code(input int w);
    return 1 << (w - 1);
  endfunction

  // Total frame length in serial clocks.
  function automatic int frame_len(input int aw, input int dw);
    return aw + dw;
  endfunction

endpackage

// File: rtl/dpot_sync.sv
module dpot_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/dpot_serial_rx.sv
module dpot_serial_rx
  import dpot_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic              cs_n_i,
  output logic              frm_valid_o,
  output logic [ADDR_W-1:0] frm_addr_o,
  output logic [DATA_W-1:0] frm_data_o
);
  localparam int FRAME_W = frame_len(ADDR_W, DATA_W);
  localparam int CNT_W   = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);

  // Synchronised serial lines: {cs_n, sclk, sdi}; idle select is high.
  logic [2:0] raw_s, syn_s;
  assign raw_s = {cs_n_i, sclk_i, sdi_i};

  dpot_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (raw_s),
    .q_o  (syn_s)
  );

  logic cs_s, sclk_s, sdi_s;
  assign cs_s   = syn_s[2];
  assign sclk_s = syn_s[1];
  assign sdi_s  = syn_s[0];

  logic cs_q, sclk_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 1'b1;
      sclk_q <= 1'b0;
    end else begin
      cs_q   <= cs_s;
      sclk_q <= sclk_s;
    end
  end

  // Named internal events.
  logic bit_tick, cs_rise;
  assign bit_tick = sclk_s & ~sclk_q & ~cs_s;
  assign cs_rise  = cs_s & ~cs_q;

  logic [FRAME_W-1:0] shreg_q;
  logic [CNT_W-1:0]   cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
    end else if (bit_tick) begin
      shreg_q <= {shreg_q[FRAME_W-2:0], sdi_s};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cs_s) begin
      cnt_q <= '0;
    end else if (bit_tick && cnt_q != CNT_SAT) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign frm_valid_o = cs_rise && (cnt_q == CNT_FULL);
  assign frm_addr_o  = shreg_q[FRAME_W-1 -: ADDR_W];
  assign frm_data_o  = shreg_q[DATA_W-1:0];

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_SAT); // R2
  AST_CS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> (cnt_q == '0)); // R8
  AST_NO_TICK_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> (cnt_q == '0)); // R8
endmodule

// File: rtl/dpot_latch_bank.sv
module dpot_latch_bank
  import dpot_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     preset_i,
  input  logic                     wr_en_i,
  input  logic [ADDR_W-1:0]        wr_addr_i,
  input  logic [DATA_W-1:0]        wr_data_i,
  output logic [NUM_CH*DATA_W-1:0] codes_o
);
  localparam logic [DATA_W-1:0] MID = DATA_W'(mid_code(DATA_W));

  logic [NUM_CH-1:0] sel;
  logic              addr_ok;
  assign addr_ok = ({1'b0, wr_addr_i} < (ADDR_W+1)'(NUM_CH));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic [DATA_W-1:0] code_q;
    assign sel[g] = wr_en_i && (wr_addr_i == ADDR_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        code_q <= MID;
      else if (preset_i) code_q <= MID;
      else if (sel[g])   code_q <= wr_data_i;
    end

    assign codes_o[g*DATA_W +: DATA_W] = code_q;

    AST_PRESET_MID: assert property (@(posedge clk) disable iff (!rst_n)
      preset_i |=> (code_q == MID)); // R6
    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (sel[g] && !preset_i) |=> (code_q == $past(wr_data_i))); // R3
  end

  AST_ONE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel)); // R3
  AST_BAD_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !addr_ok && !preset_i) |=> $stable(codes_o)); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_i && !preset_i) |=> $stable(codes_o)); // R2
endmodule

// File: rtl/dpot_switch_ctrl.sv
module dpot_switch_ctrl #(
  parameter int NUM_CH = 6
) (
  input  logic              shutdown_i,
  output logic [NUM_CH-1:0] a_open_o,
  output logic [NUM_CH-1:0] wb_short_o
);
  // In the power-saving state each channel opens its A terminal and
  // ties the wiper to B; the stored code is left untouched.
  for (genvar g = 0; g < NUM_CH; g++) begin : g_sw
    assign a_open_o[g]   = shutdown_i;
    assign wb_short_o[g] = shutdown_i;
  end
endmodule

// File: rtl/dpot_serial_ctrl.sv
module dpot_serial_ctrl #(
  parameter int NUM_CH      = 6,
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sclk,
  input  logic                     sdi,
  input  logic                     cs_n,
  input  logic                     preset,
  input  logic                     shutdown,
  output logic [NUM_CH*DATA_W-1:0] ch_code,
  output logic [NUM_CH-1:0]        ch_a_open,
  output logic [NUM_CH-1:0]        ch_wb_short
);
  logic              frm_valid;
  logic [ADDR_W-1:0] frm_addr;
  logic [DATA_W-1:0] frm_data;

  dpot_serial_rx #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .sclk_i     (sclk),
    .sdi_i      (sdi),
    .cs_n_i     (cs_n),
    .frm_valid_o(frm_valid),
    .frm_addr_o (frm_addr),
    .frm_data_o (frm_data)
  );

  dpot_latch_bank #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .preset_i (preset),
    .wr_en_i  (frm_valid),
    .wr_addr_i(frm_addr),
    .wr_data_i(frm_data),
    .codes_o  (ch_code)
  );

  dpot_switch_ctrl #(.NUM_CH(NUM_CH)) u_sw (
    .shutdown_i(shutdown),
    .a_open_o  (ch_a_open),
    .wb_short_o(ch_wb_short)
  );

  AST_SHDN_RETAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (shutdown && !preset && !frm_valid) |=> $stable(ch_code)); // R7
  AST_SHDN_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |-> (&ch_a_open && &ch_wb_short)); // R7
  AST_RUN_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
    !shutdown |-> (ch_a_open == '0 && ch_wb_short == '0)); // R7
endmodule

// File: tb/dpot_serial_ctrl_test.sv
`timescale 1ns/1ps
module dpot_serial_ctrl_test;
  localparam int NUM_CH = 6;
  localparam logic [7:0] MID = 8'h80;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, sdi = 1'b0, cs_n = 1'b1, preset = 1'b0, shutdown = 1'b0;
  logic [NUM_CH*8-1:0] ch_code;
  logic [NUM_CH-1:0]   ch_a_open, ch_wb_short;

  dpot_serial_ctrl uut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdi(sdi), .cs_n(cs_n),
    .preset(preset), .shutdown(shutdown), .ch_code(ch_code),
    .ch_a_open(ch_a_open), .ch_wb_short(ch_wb_short)
  );

  always #10 clk = ~clk;

  int checks = 0, failures = 0, blank = 0;
  bit done = 1'b0;
  logic [7:0] exp_code [NUM_CH];
  bit exp_shdn = 1'b0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] code_of(input int c);
    return ch_code[c*8 +: 8];
  endfunction

  // Reference model compared on every clock outside settling windows.
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      if (blank > 0) blank--;
      else begin
        for (int c = 0; c < NUM_CH; c++) chk("R3 model code", code_of(c), exp_code[c]);
        chk("R7 model a_open", ch_a_open, {NUM_CH{exp_shdn}});
        chk("R7 model wb_short", ch_wb_short, {NUM_CH{exp_shdn}});
      end
    end
  end

  task automatic send(input logic [15:0] bits, input int n);
    @(negedge clk) cs_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = bits[i];
      repeat (3) @(negedge clk);
      sclk = 1'b1;
      repeat (3) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    blank = 5;
    if (n == 11 && bits[10:8] < 3'd6 && !preset) exp_code[bits[10:8]] = bits[7:0];
    repeat (8) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    send({5'b0, a, d}, 11);
  endtask

  task automatic all_codes(input string tag);
    for (int c = 0; c < NUM_CH; c++) chk(tag, code_of(c), exp_code[c]);
  endtask

  initial begin
    for (int c = 0; c < NUM_CH; c++) exp_code[c] = MID;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R5: reset state
    for (int c = 0; c < NUM_CH; c++) chk("R5 reset code", code_of(c), MID);
    chk("R5 reset switches", {ch_a_open, ch_wb_short}, '0);

    // R1 / R3: single-channel writes, random order, MSB-first order
    wr(3'd4, 8'h01);
    chk("R1 msb-first ch4", code_of(4), 8'h01);
    chk("R3 ch3 untouched", code_of(3), MID);
    wr(3'd0, 8'h12);
    wr(3'd5, 8'hFE);
    wr(3'd3, 8'h00);
    wr(3'd1, 8'hFF);
    wr(3'd2, 8'hA5);
    chk("R3 ch0", code_of(0), 8'h12);
    chk("R3 ch5", code_of(5), 8'hFE);
    chk("R1 ch2 pattern", code_of(2), 8'hA5);
    all_codes("R3 all channels");

    // R4: unmapped addresses
    wr(3'd6, 8'h3C);
    wr(3'd7, 8'hC3);
    all_codes("R4 unmapped address");

    // R2: wrong lengths
    send({9'b0, 7'b0011111}, 7);
    all_codes("R2 short frame");
    send({4'b0, 12'b0001_0101_0101}, 12);
    all_codes("R2 long frame");

    // R8: aborted partial frame then a good one
    send({11'b0, 5'b10111}, 5);
    wr(3'd1, 8'h5A);
    chk("R8 after abort", code_of(1), 8'h5A);

    // R7: shutdown keeps codes
    @(negedge clk) shutdown = 1'b1; exp_shdn = 1'b1;
    repeat (4) @(negedge clk);
    chk("R7 a_open", ch_a_open, {NUM_CH{1'b1}});
    chk("R7 wb_short", ch_wb_short, {NUM_CH{1'b1}});
    all_codes("R7 codes kept in shutdown");
    shutdown = 1'b0; exp_shdn = 1'b0;
    repeat (2) @(negedge clk);
    chk("R7 release switches", {ch_a_open, ch_wb_short}, '0);
    all_codes("R7 codes after release");

    // R6: preset
    preset = 1'b1; blank = 2;
    for (int c = 0; c < NUM_CH; c++) exp_code[c] = MID;
    repeat (3) @(negedge clk);
    preset = 1'b0;
    for (int c = 0; c < NUM_CH; c++) chk("R6 preset midscale", code_of(c), MID);

    // R6: preset on the same edge the write lands
    @(negedge clk) cs_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 10; i >= 0; i--) begin
      sdi = logic'(((11'h233) >> i) & 1);
      repeat (3) @(negedge clk);
      sclk = 1'b1;
      repeat (3) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (2) @(negedge clk);
    cs_n = 1'b1; blank = 6;
    repeat (2) @(negedge clk);
    preset = 1'b1;
    @(negedge clk) preset = 1'b0;
    repeat (4) @(negedge clk);
    chk("R6 preset beats write ch2", code_of(2), MID);
    wr(3'd2, 8'h33);
    chk("R3 write after preset", code_of(2), 8'h33);

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog R2 actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule